// File: doc/BRIEF.md
# Flash Row Programming Sequencer

This block steps an embedded flash array through one complete row-programming cycle. A single start request carries the row base address. The block then raises the program enable and issues one block-protect read strobe. It writes a dummy byte into the target row and waits out the setup time before it raises the high-voltage enable. After a second setup wait it takes data bytes one at a time over a valid/ready handshake. It writes each byte to the array and holds it there for the minimum program time. At the end it drops the program enable, waits the hold time, drops the high voltage and waits for read recovery before it pulses done.

Every wait is a cycle count taken from a clocks-per-microsecond parameter and a time in microseconds. If a byte arrives too late, the block leaves the programming phase before the maximum program window runs out. It also tracks the high-voltage time spent on the row and refuses a byte whose worst-case cost would exceed the configured budget. After either of these aborts the block still runs the normal shutdown steps and reports an error together with done.

Top module: `flashRowSeq`

## Requirements
- R1: After a start accepted while idle, pgmEn rises one cycle after busy rises. protRd pulses for one cycle in the cycle after pgmEn rises. The dummy write follows one cycle later on flashWe, at offset 0 with data 0.
- R2: hvEn rises exactly NVS_US*CYC_PER_US cycles after the dummy-write cycle.
- R3: If data is already offered, the first data write comes PGS_US*CYC_PER_US+1 cycles after hvEn rises. Each cycle that the byte is withheld while inReady is high adds one cycle.
- R4: After a data write, the next write comes no sooner than PROG_US*CYC_PER_US cycles later, and pgmEn falls no sooner than that. With data ready, writes are PROG+1 cycles apart and pgmEn falls exactly PROG cycles after the last write.
- R5: While programming, if no byte is taken before the window runs out, pgmEn falls exactly PROG_MAX_US*CYC_PER_US cycles after the last write. When no data byte was written, the window is counted from the hvEn rise. The remaining bytes are skipped.
- R6: A row ends after ROW_BYTES data writes, or after the write of a byte offered with inLast=1, whichever comes first.
- R7: hvEn falls exactly NVH_US*CYC_PER_US cycles after pgmEn falls. pgmEn never falls while hvEn is low.
- R8: done pulses for one cycle, exactly RCV_US*CYC_PER_US cycles after hvEn falls. busy drops in the same cycle. All outputs are low after reset.
- R9: hvAcc counts the cycles since the dummy write. A byte is written only while hvAcc + PROG_MAX + NVH + 1 stays within HV_MAX_US*CYC_PER_US cycles; otherwise the row is aborted.
- R10: The byte at offset i is written at address {rowBase[ADDR_W-1:log2(ROW_BYTES)], i}, carrying the data offered with it.
- R11: startReq is ignored while busy: the address and the done count stay as for the first start.
- R12: err pulses with done only after an abort (R5 or R9). It is low for a row that completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to program one row |
| rowBase | input | ADDR_W | Any address inside the target row |
| inValid | input | 1 | Data byte offered |
| inData | input | DATA_W | Data byte |
| inLast | input | 1 | Offered byte is the last of the row |
| inReady | output | 1 | Block takes the offered byte this cycle |
| pgmEn | output | 1 | Program enable to the array |
| hvEn | output | 1 | High-voltage enable to the array |
| protRd | output | 1 | One-cycle block-protect read strobe |
| flashWe | output | 1 | Array write strobe |
| flashAddr | output | ADDR_W | Write address |
| flashData | output | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Abort flag, pulses with done |

## Verification
The assertions check the step ordering on every cycle: protRd only under pgmEn without high voltage, pgmEn falling only under hvEn, and done only with all enables low. They also bound the spacing of strobes from below by the program time and from above by the maximum window. Exact wait lengths, byte counts, addresses and the choice between a clean finish and an abort depend on the data arrival pattern, so only the bench scenarios show them. The bench sweeps row lengths, arrival delays across the window edge, starvation and a tight high-voltage budget.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PGM, S_PROT, S_DUMMY, S_NVS, S_PGS, S_BYTE, S_PROG, S_NVH, S_RCV
  } seqState_t;

  typedef enum logic [2:0] {
    W_NVS, W_PGS, W_PROG, W_NVH, W_RCV
  } waitSel_t;

  typedef struct packed {
    logic     latch;
    logic     setPgm;
    logic     clrPgm;
    logic     setHv;
    logic     clrHv;
    logic     protRd;
    logic     wrDummy;
    logic     wrByte;
    logic     loadWait;
    waitSel_t waitSel;
    logic     setErr;
    logic     finish;
  } seqStrobe_t;

  typedef struct packed {
    logic timerDone;
    logic hvOver;
    logic gapOver;
    logic rowDone;
  } seqStatus_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       inValid,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       inReady
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    inReady   = 1'b0;
    unique case (state)
      S_IDLE: if (startReq) begin
        stb.latch = 1'b1;
        nextState = S_PGM;
      end
      S_PGM: begin
        stb.setPgm = 1'b1;
        nextState  = S_PROT;
      end
      S_PROT: begin
        stb.protRd = 1'b1;
        nextState  = S_DUMMY;
      end
      S_DUMMY: begin
        stb.wrDummy  = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_NVS;
        nextState    = S_NVS;
      end
      S_NVS: if (stat.timerDone) begin
        stb.setHv    = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_PGS;
        nextState    = S_PGS;
      end
      S_PGS: if (stat.timerDone) nextState = S_BYTE;
      S_BYTE: begin
        inReady = !stat.hvOver;
        if (stat.hvOver || (!inValid && stat.gapOver)) begin
          stb.clrPgm   = 1'b1;
          stb.setErr   = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_NVH;
          nextState    = S_NVH;
        end else if (inValid) begin
          stb.wrByte   = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_PROG;
          nextState    = S_PROG;
        end
      end
      S_PROG: if (stat.timerDone) begin
        if (stat.rowDone) begin
          stb.clrPgm   = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_NVH;
          nextState    = S_NVH;
        end else begin
          nextState = S_BYTE;
        end
      end
      S_NVH: if (stat.timerDone) begin
        stb.clrHv    = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_RCV;
        nextState    = S_RCV;
      end
      S_RCV: if (stat.timerDone) begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int ROW_BYTES    = 32,
  parameter int NVS_CYC      = 80,
  parameter int PGS_CYC      = 40,
  parameter int PROG_CYC     = 240,
  parameter int PROG_MAX_CYC = 320,
  parameter int NVH_CYC      = 40,
  parameter int RCV_CYC      = 8,
  parameter int HV_MAX_CYC   = 32000
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] rowBase,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output seqStatus_t        stat,
  output logic              pgmEn,
  output logic              hvEn,
  output logic              protRd,
  output logic              flashWe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashData,
  output logic              done,
  output logic              err
);

  localparam int OFS_W     = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam int HI_W      = ADDR_W - OFS_W;
  localparam int WAIT_A    = (NVS_CYC > PGS_CYC) ? NVS_CYC : PGS_CYC;
  localparam int WAIT_B    = (PROG_CYC > NVH_CYC) ? PROG_CYC : NVH_CYC;
  localparam int WAIT_C    = (WAIT_A > WAIT_B) ? WAIT_A : WAIT_B;
  localparam int WAIT_MAX  = (WAIT_C > RCV_CYC) ? WAIT_C : RCV_CYC;
  localparam int TMR_W     = $clog2(WAIT_MAX + 1);
  localparam int GAP_W     = $clog2(PROG_MAX_CYC + 1);
  localparam int HV_W      = $clog2(HV_MAX_CYC + 1) + 1;
  localparam int HV_BUDGET = HV_MAX_CYC - PROG_MAX_CYC - NVH_CYC - 1;
  localparam int GAP_LIM   = PROG_MAX_CYC - 1;

  logic [TMR_W-1:0] timer, waitLoad;
  logic [GAP_W-1:0] gapCnt;
  logic [HV_W-1:0]  hvAcc;
  logic [OFS_W-1:0] ofs;
  logic [HI_W-1:0]  baseHi;
  logic             rowDone, errFlag;

  always_comb begin
    unique case (stb.waitSel)
      W_NVS:   waitLoad = TMR_W'(NVS_CYC - 1);
      W_PGS:   waitLoad = TMR_W'(PGS_CYC - 1);
      W_PROG:  waitLoad = TMR_W'(PROG_CYC - 1);
      W_NVH:   waitLoad = TMR_W'(NVH_CYC - 1);
      default: waitLoad = TMR_W'(RCV_CYC - 1);
    endcase
  end

  // wait timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timer <= '0;
    else if (stb.loadWait) timer <= waitLoad;
    else if (timer != '0)  timer <= timer - 1'b1;
  end

  // gap since the last write or since high voltage came on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          gapCnt <= '0;
    else if (stb.wrByte || stb.setHv)   gapCnt <= '0;
    else if (gapCnt != GAP_W'(PROG_MAX_CYC)) gapCnt <= gapCnt + 1'b1;
  end

  // high-voltage time spent on this row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    hvAcc <= '0;
    else if (stb.wrDummy)         hvAcc <= '0;
    else if (hvAcc != '1)         hvAcc <= hvAcc + 1'b1;
  end

  // row address, offset and end-of-row tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      ofs     <= '0;
      rowDone <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (stb.latch) begin
        baseHi  <= rowBase[ADDR_W-1:OFS_W];
        errFlag <= 1'b0;
      end
      if (stb.wrDummy) begin
        ofs     <= '0;
        rowDone <= 1'b0;
      end
      if (stb.wrByte) begin
        ofs     <= ofs + 1'b1;
        rowDone <= inLast || (ofs == OFS_W'(ROW_BYTES - 1));
      end
      if (stb.setErr) errFlag <= 1'b1;
    end
  end

  // registered array controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmEn     <= 1'b0;
      hvEn      <= 1'b0;
      protRd    <= 1'b0;
      flashWe   <= 1'b0;
      flashAddr <= '0;
      flashData <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (stb.setPgm)      pgmEn <= 1'b1;
      else if (stb.clrPgm) pgmEn <= 1'b0;
      if (stb.setHv)       hvEn  <= 1'b1;
      else if (stb.clrHv)  hvEn  <= 1'b0;
      protRd  <= stb.protRd;
      flashWe <= stb.wrDummy || stb.wrByte;
      if (stb.wrDummy) begin
        flashAddr <= {baseHi, OFS_W'(0)};
        flashData <= '0;
      end else if (stb.wrByte) begin
        flashAddr <= {baseHi, ofs};
        flashData <= inData;
      end
      done <= stb.finish;
      err  <= stb.finish && errFlag;
    end
  end

  assign stat.timerDone = (timer == '0);
  assign stat.gapOver   = (gapCnt >= GAP_W'(GAP_LIM));
  assign stat.hvOver    = (hvAcc > HV_W'(HV_BUDGET));
  assign stat.rowDone   = rowDone;

endmodule

// File: rtl/flashRowSeq.sv
module flashRowSeq
  import flash_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ROW_BYTES   = 32,
  parameter int NVS_US      = 10,
  parameter int PGS_US      = 5,
  parameter int PROG_US     = 30,
  parameter int PROG_MAX_US = 40,
  parameter int NVH_US      = 5,
  parameter int RCV_US      = 1,
  parameter int HV_MAX_US   = 4000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] rowBase,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              pgmEn,
  output logic              hvEn,
  output logic              protRd,
  output logic              flashWe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashData,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int NVS_CYC      = NVS_US * CYC_PER_US;
  localparam int PGS_CYC      = PGS_US * CYC_PER_US;
  localparam int PROG_CYC     = PROG_US * CYC_PER_US;
  localparam int PROG_MAX_CYC = PROG_MAX_US * CYC_PER_US;
  localparam int NVH_CYC      = NVH_US * CYC_PER_US;
  localparam int RCV_CYC      = RCV_US * CYC_PER_US;
  localparam int HV_MAX_CYC   = HV_MAX_US * CYC_PER_US;

  seqStrobe_t stb;
  seqStatus_t stat;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .inValid(inValid),
    .stat(stat), .stb(stb), .busy(busy), .inReady(inReady)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES),
    .NVS_CYC(NVS_CYC), .PGS_CYC(PGS_CYC), .PROG_CYC(PROG_CYC),
    .PROG_MAX_CYC(PROG_MAX_CYC), .NVH_CYC(NVH_CYC), .RCV_CYC(RCV_CYC),
    .HV_MAX_CYC(HV_MAX_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowBase(rowBase), .inData(inData),
    .inLast(inLast), .stat(stat), .pgmEn(pgmEn), .hvEn(hvEn), .protRd(protRd),
    .flashWe(flashWe), .flashAddr(flashAddr), .flashData(flashData),
    .done(done), .err(err)
  );

endmodule

// File: rtl/flashRowSeqChk.sv
module flashRowSeqChk #(
  parameter int NVS_CYC      = 80,
  parameter int PROG_CYC     = 240,
  parameter int PROG_MAX_CYC = 320
)(
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic pgmEn,
  input logic hvEn,
  input logic protRd,
  input logic flashWe,
  input logic done,
  input logic err
);

  logic [15:0] weGap, hvGap;
  logic [1:0]  wesInRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weGap    <= '0;
      hvGap    <= '0;
      wesInRun <= '0;
    end else begin
      if (flashWe)             weGap <= 16'd1;
      else if (weGap != '1)    weGap <= weGap + 1'b1;
      if (!hvEn)               hvGap <= '0;
      else if (flashWe)        hvGap <= 16'd1;
      else if (hvGap != '1)    hvGap <= hvGap + 1'b1;
      if (!busy)               wesInRun <= '0;
      else if (flashWe && wesInRun != 2'd3) wesInRun <= wesInRun + 1'b1;
    end
  end

  a_r1_prot_in_order: assert property (@(posedge clk) disable iff (!rstN)
    protRd |-> (pgmEn && !hvEn && busy));

  a_r2_nvs_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hvEn) |-> (pgmEn && weGap >= NVS_CYC));

  a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (flashWe && wesInRun >= 2'd2) |-> (weGap >= PROG_CYC));

  a_r4_pgm_release_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pgmEn) && wesInRun >= 2'd2) |-> (weGap >= PROG_CYC));

  a_r5_window_max: assert property (@(posedge clk) disable iff (!rstN)
    (pgmEn && hvEn && !flashWe) |-> (hvGap < PROG_MAX_CYC));

  a_r7_pgm_under_hv: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgmEn) |-> hvEn);

  a_r7_hv_after_pgm: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hvEn) |-> !pgmEn);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !pgmEn && !hvEn));

  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

endmodule

bind flashRowSeq flashRowSeqChk #(
  .NVS_CYC(NVS_CYC), .PROG_CYC(PROG_CYC), .PROG_MAX_CYC(PROG_MAX_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .pgmEn(pgmEn), .hvEn(hvEn),
  .protRd(protRd), .flashWe(flashWe), .done(done), .err(err)
);

// File: tb/tb_flashRowSeq.sv
`timescale 1ns/1ps
module tb_flashRowSeq;

  localparam int CPU = 2, ROWB = 8;
  localparam int NVS = 3*CPU, P = 2*CPU, R = 4*CPU, RM = 6*CPU, H = 2*CPU, RC = 1*CPU;
  localparam int HVN = 200*CPU, HVT = 25*CPU;

  logic clk = 0, rstN = 0;
  always #4 clk = ~clk;

  logic startA = 0, startB = 0, inValid = 0, inLast = 0, selB = 0;
  logic [15:0] rowBase = '0;
  logic [7:0]  inData = '0;
  logic rdyA, pgmA, hvA, prA, weA, busyA, doneA, errA;
  logic rdyB, pgmB, hvB, prB, weB, busyB, doneB, errB;
  logic [15:0] addrA, addrB;
  logic [7:0]  dataA, dataB;

  flashRowSeq #(.CYC_PER_US(CPU), .ROW_BYTES(ROWB), .NVS_US(3), .PGS_US(2), .PROG_US(4),
    .PROG_MAX_US(6), .NVH_US(2), .RCV_US(1), .HV_MAX_US(200)) dut (
    .clk(clk), .rstN(rstN), .startReq(startA), .rowBase(rowBase), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inReady(rdyA), .pgmEn(pgmA), .hvEn(hvA),
    .protRd(prA), .flashWe(weA), .flashAddr(addrA), .flashData(dataA),
    .busy(busyA), .done(doneA), .err(errA));

  flashRowSeq #(.CYC_PER_US(CPU), .ROW_BYTES(ROWB), .NVS_US(3), .PGS_US(2), .PROG_US(4),
    .PROG_MAX_US(6), .NVH_US(2), .RCV_US(1), .HV_MAX_US(25)) dutTight (
    .clk(clk), .rstN(rstN), .startReq(startB), .rowBase(rowBase), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inReady(rdyB), .pgmEn(pgmB), .hvEn(hvB),
    .protRd(prB), .flashWe(weB), .flashAddr(addrB), .flashData(dataB),
    .busy(busyB), .done(doneB), .err(errB));

  wire mRdy  = selB ? rdyB : rdyA;
  wire mPgm  = selB ? pgmB : pgmA;
  wire mHv   = selB ? hvB : hvA;
  wire mPr   = selB ? prB : prA;
  wire mWe   = selB ? weB : weA;
  wire mBusy = selB ? busyB : busyA;
  wire mDone = selB ? doneB : doneA;
  wire mErr  = selB ? errB : errA;
  wire [15:0] mAddr = selB ? addrB : addrA;
  wire [7:0]  mData = selB ? dataB : dataA;

  int checks = 0, errors = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus state
  bit kick = 0, poke = 0, pendTake = 0;
  int idx = 0, hold = 0, limit = 0, lastIdx = 99, delay = 0, runCyc = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  always @(negedge clk) begin
    runCyc++;
    startA = 0; startB = 0;
    if (kick) begin
      if (selB) startB = 1; else startA = 1;
      kick = 0; runCyc = 0; idx = 0; hold = delay; pendTake = 0;
    end else if (poke && runCyc == 20) begin
      if (selB) startB = 1; else startA = 1;
      rowBase = 16'hBEEF;
    end
    if (pendTake) begin idx++; hold = delay; end
    if (hold > 0) begin
      inValid = 0;
      if (mRdy) hold--;
    end else begin
      inValid = (idx < limit);
    end
    inData = pat(idx);
    inLast = (idx == lastIdx);
    pendTake = inValid && mRdy;
  end

  // monitor
  int cyc = 0, weCnt, protCnt, doneCnt, strayErr;
  int tBusy, tPgmR, tProt, tDummy, tHvR, tPgmF, tHvF, tDone, errAtDone, busyAtDone;
  int dumAddr, dumData;
  int tWe[16], aWe[16], dWe[16];
  logic pPgm = 0, pHv = 0, pBusy = 0;

  always @(negedge clk) begin
    cyc++;
    if (mBusy && !pBusy) tBusy = cyc;
    if (mPgm && !pPgm) tPgmR = cyc;
    if (!mPgm && pPgm) tPgmF = cyc;
    if (mHv && !pHv) tHvR = cyc;
    if (!mHv && pHv) tHvF = cyc;
    if (mPr) begin tProt = cyc; protCnt++; end
    if (mWe) begin
      if (weCnt == 0) begin tDummy = cyc; dumAddr = int'(mAddr); dumData = int'(mData); end
      else if (weCnt <= 16) begin
        tWe[weCnt-1] = cyc; aWe[weCnt-1] = int'(mAddr); dWe[weCnt-1] = int'(mData);
      end
      weCnt++;
    end
    if (mDone) begin tDone = cyc; doneCnt++; errAtDone = int'(mErr); busyAtDone = int'(mBusy); end
    if (mErr && !mDone) strayErr++;
    pPgm = mPgm; pHv = mHv; pBusy = mBusy;
  end

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", wdog);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic runRow(input bit tight, input logic [15:0] base, input int lst,
                        input int lim, input int d, input bit pk);
    int hvMax, budget, aE, gE, expCnt, expErr, n;
    bit ended;
    string tg;
    @(negedge clk);
    selB = tight; rowBase = base; lastIdx = lst; limit = lim; delay = d; poke = pk;
    weCnt = 0; protCnt = 0; doneCnt = 0; strayErr = 0;
    kick = 1;
    n = 0;
    while (doneCnt == 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    poke = 0;
    // expected from the requirements
    hvMax = tight ? HVT : HVN;
    budget = hvMax - RM - H - 1;
    aE = NVS + P; gE = P; expCnt = 0; expErr = 0; ended = 0;
    while (!ended) begin
      if (expCnt == ROWB || (expCnt > 0 && expCnt - 1 == lst)) ended = 1;
      else if (expCnt >= lim || aE + d > budget || gE + d > RM - 1) begin expErr = 1; ended = 1; end
      else begin expCnt++; aE = aE + d + 1 + R; gE = R; end
    end
    tg = $sformatf("[tight=%0d last=%0d lim=%0d d=%0d]", tight, lst, lim, d);
    chk(doneCnt, 1, {"R11 single done ", tg});
    chk(weCnt - 1, expCnt, {"R6/R9 bytes written ", tg});
    chk(errAtDone, expErr, {"R12 err at done ", tg});
    chk(strayErr, 0, {"R12 err only with done ", tg});
    chk(tPgmR - tBusy, 1, {"R1 busy to pgmEn ", tg});
    chk(protCnt, 1, {"R1 one protect read ", tg});
    chk(tProt - tPgmR, 1, {"R1 pgmEn to protRd ", tg});
    chk(tDummy - tProt, 1, {"R1 protRd to dummy write ", tg});
    chk(dumAddr, int'({base[15:3], 3'b000}), {"R1 dummy address ", tg});
    chk(dumData, 0, {"R1 dummy data ", tg});
    chk(tHvR - tDummy, NVS, {"R2 nvs wait ", tg});
    if (expCnt > 0) chk(tWe[0] - tHvR, P + 1 + d, {"R3 pgs to first byte ", tg});
    for (int i = 1; i < expCnt; i++)
      chk(tWe[i] - tWe[i-1], R + 1 + d, $sformatf("R4 byte gap %0d %s", i, tg));
    for (int i = 0; i < expCnt; i++) begin
      chk(aWe[i], int'({base[15:3], 3'b000}) + i, $sformatf("R10 address %0d %s", i, tg));
      chk(dWe[i], int'(pat(i)), $sformatf("R10 data %0d %s", i, tg));
    end
    if (!expErr)
      chk(tPgmF - tWe[expCnt-1], R, {"R4 last byte to pgm off ", tg});
    else if (tight)
      chk(tPgmF - tWe[expCnt-1], R + 1, {"R9 budget abort timing ", tg});
    else
      chk(tPgmF - ((expCnt == 0) ? tHvR : tWe[expCnt-1]), RM, {"R5 window abort ", tg});
    chk(tHvF - tPgmF, H, {"R7 nvh hold ", tg});
    chk(tDone - tHvF, RC, {"R8 recovery ", tg});
    chk(busyAtDone, 0, {"R8 busy low with done ", tg});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(int'({busyA, pgmA, hvA, weA, prA, doneA, errA, rdyA}), 0, "R8 reset state");
    // full row with a restart attempt mid-run
    runRow(0, 16'h1234, 99, ROWB, 0, 1);
    // row length sweep via the last marker
    for (int l = 0; l < ROWB - 1; l++) runRow(0, 16'h0A55, l, ROWB, 0, 0);
    // starvation aborts
    runRow(0, 16'h7F00, 99, 2, 0, 0);
    runRow(0, 16'h0010, 99, 0, 0, 0);
    // arrival delay sweep across the window edge
    for (int d = 1; d <= 5; d++) runRow(0, 16'h3C3C, 99, ROWB, d, 0);
    // tight high-voltage budget
    runRow(1, 16'h4448, 99, ROWB, 0, 0);
    runRow(1, 16'h4448, 1, ROWB, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule